// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Access Arbitration

This block decides, cycle by cycle, whether a DRAM array is refreshing a row or is free for one read/write slot. A period counter marks the start of each refresh period. At that point a burst is loaded that refreshes every row once, back to back. Each row holds the array busy for a fixed number of cycles. A row counter steps through the rows and wraps to zero after the last one.

Ordinary accesses use a request/grant handshake. A grant is a one-cycle slot issued in the cycle after the request. A grant is only issued when no refresh will occupy that cycle. A pending refresh always beats a new request, but a slot that was already granted runs to its end first.

A free-running counter counts every cycle that is not spent refreshing. Reading it across one period gives the share of time left for accesses. With the default parameters (2^14 rows, 5 cycles per row, 200000-cycle period at 100 MHz) that share is about 59%.

Top module: `refresh_scheduler`

## Requirements
- R1: A synchronous active-high reset clears the period counter, the row counter, the pending-row count, the busy state, the grant and the idle counter. In the first cycle after reset, refBusy=0, refRow=0, accGnt=0 and idleCount=0.
- R2: accGnt is high in cycle t+1 exactly when accReq was high in cycle t and the array is not refreshing in cycle t+1. Each grant is a slot of a single cycle.
- R3: accGnt and refBusy are never high in the same cycle.
- R4: Once a burst is pending and the array is idle, new requests are denied and refBusy rises in the next cycle. A grant issued before the burst became pending keeps its slot, and the refresh follows it.
- R5: The burst is loaded at the end of cycle 0 of each period. refBusy is then high from cycle 2 of the period for ROWS*REF_CYCLES consecutive cycles, where ROWS = 2^ROW_BITS.
- R6: While busy, refRow gives the row being refreshed. Rows run 0, 1, ..., ROWS-1, each held for REF_CYCLES cycles. After the last row, refRow wraps to 0.
- R7: idleCount increases by one for every cycle with refBusy low and holds during refresh. At cycle PERIOD_CYCLES after reset it equals PERIOD_CYCLES - ROWS*REF_CYCLES.
- R8: The period repeats every PERIOD_CYCLES cycles, and each new period starts a new burst from row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accReq | input | 1 | Read/write slot request |
| accGnt | output | 1 | One-cycle access slot granted |
| refBusy | output | 1 | Array is refreshing this cycle |
| refRow | output | ROW_BITS | Row under refresh / next row to refresh |
| idleCount | output | CNT_W | Count of cycles not spent refreshing |

## Verification
Every output comes from a register, so the bench counts cycles from the first cycle after reset and samples on the falling edge.

- A request in cycle t is due as a grant in cycle t+1.
- The burst loads at the end of period cycle 0, becomes visible in cycle 1 and raises refBusy in cycle 2.
- refRow changes one cycle after a row's last busy cycle.
- idleCount, read in cycle k, counts the idle cycles 0..k-1, so its expected value at cycle PERIOD_CYCLES is the period length minus the busy cycles.

The checks compute each expected value from the cycle index using exactly these offsets.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_REFRESH = 1'b1
  } refState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBurst;  // period start: arm a full burst
    logic runRow;     // array refreshing this cycle
    logic finishRow;  // last busy cycle of current row
    logic grantNext;  // grant an access slot next cycle
  } refStrobes_t;

endpackage

// File: rtl/refresh_dp.sv
module refresh_dp
  import refresh_pkg::*;
#(
  parameter int ROW_BITS      = 14,
  parameter int REF_CYCLES    = 5,
  parameter int PERIOD_CYCLES = 200000,
  parameter int CNT_W         = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  refStrobes_t         strb,
  output logic                periodZero,
  output logic                rowsPending,
  output logic                lastRow,
  output logic                rowDone,
  output logic [ROW_BITS-1:0] rowAddr,
  output logic [CNT_W-1:0]    idleCnt,
  output logic                accGnt
);

  localparam int ROWS   = 1 << ROW_BITS;
  localparam int PER_W  = $clog2(PERIOD_CYCLES);
  localparam int BUSY_W = $clog2(REF_CYCLES + 1);
  localparam int LEFT_W = ROW_BITS + 1;

  logic [PER_W-1:0]  periodCnt;
  logic [BUSY_W-1:0] busyCnt;
  logic [LEFT_W-1:0] rowsLeft;

  assign periodZero  = (periodCnt == '0);
  assign rowsPending = (rowsLeft != '0);
  assign lastRow     = (rowsLeft == LEFT_W'(1));
  assign rowDone     = (busyCnt == BUSY_W'(REF_CYCLES - 1));

  // period counter
  always_ff @(posedge clk) begin
    if (rst)
      periodCnt <= '0;
    else if (periodCnt == PER_W'(PERIOD_CYCLES - 1))
      periodCnt <= '0;
    else
      periodCnt <= periodCnt + PER_W'(1);
  end

  // rows still owed in this period
  always_ff @(posedge clk) begin
    if (rst)
      rowsLeft <= '0;
    else if (strb.loadBurst)
      rowsLeft <= LEFT_W'(ROWS);
    else if (strb.finishRow)
      rowsLeft <= rowsLeft - LEFT_W'(1);
  end

  // cycles spent on the current row
  always_ff @(posedge clk) begin
    if (rst || strb.finishRow || !strb.runRow)
      busyCnt <= '0;
    else
      busyCnt <= busyCnt + BUSY_W'(1);
  end

  // row address, wraps naturally at ROWS
  always_ff @(posedge clk) begin
    if (rst)
      rowAddr <= '0;
    else if (strb.finishRow)
      rowAddr <= rowAddr + ROW_BITS'(1);
  end

  // cycles available for access
  always_ff @(posedge clk) begin
    if (rst)
      idleCnt <= '0;
    else if (!strb.runRow)
      idleCnt <= idleCnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)
      accGnt <= 1'b0;
    else
      accGnt <= strb.grantNext;
  end

  assert_row_step_R6: assert property (@(posedge clk) disable iff (rst)
    (rowAddr != $past(rowAddr)) |-> (rowAddr == $past(rowAddr) + ROW_BITS'(1)));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    strb.runRow |=> $stable(idleCnt));

  assert_busy_bound_R5: assert property (@(posedge clk) disable iff (rst)
    busyCnt < BUSY_W'(REF_CYCLES));

  assert_period_bound_R8: assert property (@(posedge clk) disable iff (rst)
    periodCnt < PER_W'(PERIOD_CYCLES));

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        accReq,
  input  logic        periodZero,
  input  logic        rowsPending,
  input  logic        lastRow,
  input  logic        rowDone,
  output refStrobes_t strb,
  output logic        busy
);

  refState_e state, nextState;

  always_comb begin
    nextState      = state;
    strb.loadBurst = periodZero;
    strb.runRow    = (state == ST_REFRESH);
    strb.finishRow = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (rowsPending) nextState = ST_REFRESH;
      end
      ST_REFRESH: begin
        if (rowDone) begin
          strb.finishRow = 1'b1;
          if (lastRow) nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    strb.grantNext = accReq && (nextState == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst)
      state <= ST_IDLE;
    else
      state <= nextState;
  end

  assign busy = (state == ST_REFRESH);

  assert_refresh_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && rowsPending) |=> busy);

  assert_burst_continues_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !(rowDone && lastRow)) |=> busy);

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refresh_pkg::*;
#(
  parameter int ROW_BITS      = 14,
  parameter int REF_CYCLES    = 5,
  parameter int PERIOD_CYCLES = 200000,
  parameter int CNT_W         = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accReq,
  output logic                accGnt,
  output logic                refBusy,
  output logic [ROW_BITS-1:0] refRow,
  output logic [CNT_W-1:0]    idleCount
);

  refStrobes_t strb;
  logic periodZero, rowsPending, lastRow, rowDone;

  refresh_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .accReq      (accReq),
    .periodZero  (periodZero),
    .rowsPending (rowsPending),
    .lastRow     (lastRow),
    .rowDone     (rowDone),
    .strb        (strb),
    .busy        (refBusy)
  );

  refresh_dp #(
    .ROW_BITS      (ROW_BITS),
    .REF_CYCLES    (REF_CYCLES),
    .PERIOD_CYCLES (PERIOD_CYCLES),
    .CNT_W         (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .periodZero  (periodZero),
    .rowsPending (rowsPending),
    .lastRow     (lastRow),
    .rowDone     (rowDone),
    .rowAddr     (refRow),
    .idleCnt     (idleCount),
    .accGnt      (accGnt)
  );

  assert_no_gnt_busy_R3: assert property (@(posedge clk) disable iff (rst)
    !(accGnt && refBusy));

  assert_gnt_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
    accGnt |-> $past(accReq));

endmodule

// File: tb/tb_refresh_scheduler.sv
module tb_refresh_scheduler;

  localparam int ROW_BITS = 5;
  localparam int REF      = 5;
  localparam int PERIOD   = 390;
  localparam int CNT_W    = 32;
  localparam int ROWS     = 1 << ROW_BITS;
  localparam int BURST    = ROWS * REF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic accReq = 1'b0;
  logic accGnt, refBusy;
  logic [ROW_BITS-1:0] refRow;
  logic [CNT_W-1:0] idleCount;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  refresh_scheduler #(
    .ROW_BITS(ROW_BITS), .REF_CYCLES(REF), .PERIOD_CYCLES(PERIOD), .CNT_W(CNT_W)
  ) dut (
    .clk(clk), .rst(rst), .accReq(accReq), .accGnt(accGnt),
    .refBusy(refBusy), .refRow(refRow), .idleCount(idleCount)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic goTo(input int target);
    while (cyc < target) step();
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc = 0;
  endtask

  // R1 reset state, R2 grant latency, R4 granted slot runs before refresh
  task automatic testResetAndGrant();
    chk("R1 refBusy after reset", refBusy, 0);
    chk("R1 refRow after reset", refRow, 0);
    chk("R1 accGnt after reset", accGnt, 0);
    chk("R1 idleCount after reset", idleCount, 0);
    accReq = 1'b1;
    step();
    chk("R2 grant one cycle after request", accGnt, 1);
    chk("R4 granted slot before refresh, busy low", refBusy, 0);
    step();
    chk("R4 refresh wins over new request", accGnt, 0);
    chk("R5 refBusy rises in period cycle 2", refBusy, 1);
  endtask

  // R3 no grant while busy, R5 burst length, R6 row order and wrap
  task automatic testBurst();
    int badBusy = 0;
    int badGnt  = 0;
    int badRow  = 0;
    int firstBadRow = -1;
    int firstExpRow = -1;
    for (int i = 0; i < BURST; i++) begin
      if (refBusy !== 1'b1) badBusy++;
      if (accGnt !== 1'b0) badGnt++;
      if (refRow !== ROW_BITS'((cyc - 2) / REF)) begin
        if (firstBadRow < 0) begin
          firstBadRow = int'(refRow);
          firstExpRow = (cyc - 2) / REF;
        end
        badRow++;
      end
      step();
    end
    chk("R5 busy cycles missing in burst", badBusy, 0);
    chk("R3 grants during refresh", badGnt, 0);
    if (badRow != 0) chk("R6 row sequence", firstBadRow, firstExpRow);
    else chk("R6 row sequence mismatches", badRow, 0);
    chk("R5 refBusy low after burst", refBusy, 0);
    chk("R6 refRow wraps to 0", refRow, 0);
    chk("R2 grant resumes after burst", accGnt, 1);
  endtask

  // R7 idle accounting, R8 period repeat, R2 no request no grant
  task automatic testIdleAndPeriod();
    longint idleAtBusy;
    accReq = 1'b0;
    step();
    chk("R2 no grant without request", accGnt, 0);
    goTo(PERIOD);
    chk("R7 idle cycles over one period", idleCount, PERIOD - BURST);
    chk("R7 idle share in percent", (longint'(idleCount) * 100) / PERIOD,
        ((PERIOD - BURST) * 100) / PERIOD);
    step();
    chk("R8 not busy in new period cycle 1", refBusy, 0);
    step();
    chk("R8 new burst starts", refBusy, 1);
    chk("R8 new burst from row 0", refRow, 0);
    idleAtBusy = idleCount;
    goTo(PERIOD + 2 + 3 * REF + 1);
    chk("R7 idleCount holds during refresh", idleCount, idleAtBusy);
    chk("R6 row during second burst", refRow, 3);
  endtask

  // R1 reset in mid-burst
  task automatic testMidReset();
    accReq = 1'b1;
    doReset();
    chk("R1 refBusy after mid-burst reset", refBusy, 0);
    chk("R1 refRow after mid-burst reset", refRow, 0);
    chk("R1 idleCount after mid-burst reset", idleCount, 0);
    chk("R1 accGnt after mid-burst reset", accGnt, 0);
    step();
    chk("R2 grant after reset", accGnt, 1);
    step();
    chk("R5 burst after reset", refBusy, 1);
    accReq = 1'b0;
  endtask

  initial begin
    doReset();
    testResetAndGrant();
    testBurst();
    testIdleAndPeriod();
    testMidReset();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule